// File: doc/BRIEF.md
# Dual-Capture Pulse Width Timer

This block measures how long a digital input stays at a level. A 16-bit up-counter runs without stopping. It advances once per count-clock tick, which arrives as a single-cycle enable on the system clock, and it rolls over from all ones to zero. The input is assumed to be synchronous to the system clock already. It is sampled only on ticks, and a new level is accepted only once two successive samples agree. This removes glitches shorter than one sampling period.

A 2-bit mode input picks the trigger edge: rising, falling or either. When the trigger edge is accepted, the counter value is latched into the primary capture register and a primary interrupt strobe fires. In the two single-edge modes, the opposite edge loads the secondary capture register and fires a secondary strobe. Software reads both registers and takes their difference modulo 2^16 to get the pulse width in count clocks. Widths are valid up to one full counter period. A sticky overflow flag records every rollover and is cleared by a write-one-to-clear strobe.

Top module: `pulse_width_capture`

## Requirements
- R1: After synchronous reset, `count`, `cap_pri`, `cap_sec` and `ovf` are zero, both interrupt strobes are low, and the accepted input level is low.
- R2: `count` rises by exactly one on each cycle with `tick` high. It holds when `tick` is low, and it rolls over from 16'hFFFF to 16'h0000.
- R3: A new input level is accepted only if it is seen on two successive ticks. A level held for one tick only loads no register and raises no strobe.
- R4: Encoding of `edge_sel` for the primary trigger: 2'b00 is the falling edge, 2'b01 is the rising edge, and 2'b10 or 2'b11 is either edge.
- R5: Tick index n counts ticks from reset, so `count` equals n mod 2^16 at tick n. If the input changes between tick k and tick k+1 and the resulting edge is a primary trigger, `cap_pri` is loaded at tick k+3 with the value (k+3) mod 2^16. `irq_pri` is high for the cycle after that tick.
- R6: In the single-edge modes, the edge opposite the trigger loads `cap_sec` with the same timing as R5 and raises `irq_sec`. In either-edge mode, `cap_sec` and `irq_sec` are never touched.
- R7: `ovf` is set on the tick that rolls the counter over. It stays set until `ovf_clr` is high for a cycle. If a rollover happens in the same cycle as a clear, the rollover wins.
- R8: For a pulse of w ticks (2 ≤ w < 65536), (`cap_sec` − `cap_pri`) mod 2^16 equals w, even when the pulse spans a rollover.
- R9: Each interrupt strobe is high for exactly one cycle per load of its register, and the two strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Count-clock enable, one system cycle wide |
| cap_in | input | 1 | Measured input, already synchronous |
| edge_sel | input | 2 | Trigger edge mode (see R4) |
| ovf_clr | input | 1 | Write-one-to-clear for the overflow flag |
| count | output | 16 | Free-running counter value |
| cap_pri | output | 16 | Primary capture register |
| cap_sec | output | 16 | Secondary capture register |
| irq_pri | output | 1 | Primary capture strobe |
| irq_sec | output | 1 | Secondary capture strobe |
| ovf | output | 1 | Sticky counter rollover flag |

## Verification
The hardest case to reach from the ports is a pulse that straddles the counter rollover. That case needs tens of thousands of ticks before the leading edge. The stimulus holds `tick` high on every cycle to run the counter up to just below all ones. It then drives a 10-tick pulse in rising mode, which tests the modular width and the overflow flag in one pass. Before that, a sweep covers every mode value and pulse widths of one to eight ticks at several tick spacings. This sweep reaches the one-tick glitch and the two-tick minimum, where the first capture lands while the second edge is still being filtered.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

  typedef enum logic [1:0] {
    TRIG_FALL  = 2'b00,
    TRIG_RISE  = 2'b01,
    TRIG_ANY   = 2'b10,
    TRIG_ANY_B = 2'b11
  } trig_mode_e;

  // Primary route: does this accepted edge trigger the primary register?
  function automatic logic route_primary(input logic [1:0] mode,
                                         input logic rise,
                                         input logic fall);
    if (mode[1]) return rise | fall;
    if (mode[0]) return rise;
    return fall;
  endfunction

  // Secondary route: opposite edge, only in single-edge modes
  function automatic logic route_secondary(input logic [1:0] mode,
                                           input logic rise,
                                           input logic fall);
    if (mode[1]) return 1'b0;
    if (mode[0]) return fall;
    return rise;
  endfunction

endpackage

// File: rtl/pwc_counter.sv
module pwc_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          ovf_clr,
  output logic [CW-1:0] count,
  output logic          ovf,
  output logic          wrap
);

  localparam logic [CW-1:0] ALL_ONES = {CW{1'b1}};

  function automatic logic [CW-1:0] step(input logic [CW-1:0] c);
    return c + 1'b1;
  endfunction

  assign wrap = tick && (count == ALL_ONES);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      if (tick) count <= step(count);
      if (wrap)         ovf <= 1'b1;
      else if (ovf_clr) ovf <= 1'b0;
    end
  end

endmodule

// File: rtl/pwc_edge_filter.sv
module pwc_edge_filter #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic din,
  output logic level,
  output logic rise_ok,
  output logic fall_ok
);

  localparam int HW = DEPTH - 1;

  logic [HW-1:0] hist;
  logic          agree;
  logic          confirm;

  // current sample plus HW earlier samples all equal
  assign agree   = (hist == {HW{din}});
  assign confirm = tick && agree && (din != level);
  assign rise_ok = confirm && din;
  assign fall_ok = confirm && !din;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist  <= '0;
      level <= 1'b0;
    end else if (tick) begin
      hist <= HW'({hist, din});
      if (confirm) level <= din;
    end
  end

endmodule

// File: rtl/pwc_capture.sv
module pwc_capture #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          rise_ok,
  input  logic          fall_ok,
  input  logic [1:0]    edge_sel,
  input  logic [CW-1:0] count,
  output logic [CW-1:0] cap_pri,
  output logic [CW-1:0] cap_sec,
  output logic          irq_pri,
  output logic          irq_sec,
  output logic          hit_pri,
  output logic          hit_sec
);

  import pwc_pkg::*;

  logic pend_pri, pend_sec;

  assign hit_pri = route_primary(edge_sel, rise_ok, fall_ok);
  assign hit_sec = route_secondary(edge_sel, rise_ok, fall_ok);

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_pri  <= '0;
      cap_sec  <= '0;
      irq_pri  <= 1'b0;
      irq_sec  <= 1'b0;
      pend_pri <= 1'b0;
      pend_sec <= 1'b0;
    end else begin
      irq_pri <= 1'b0;
      irq_sec <= 1'b0;
      if (tick) begin
        if (pend_pri) begin
          cap_pri <= count;
          irq_pri <= 1'b1;
        end
        if (pend_sec) begin
          cap_sec <= count;
          irq_sec <= 1'b1;
        end
        pend_pri <= hit_pri;
        pend_sec <= hit_sec;
      end
    end
  end

endmodule

// File: rtl/pulse_width_capture.sv
module pulse_width_capture #(
  parameter int CNT_W      = 16,
  parameter int FILT_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             cap_in,
  input  logic [1:0]       edge_sel,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] cap_pri,
  output logic [CNT_W-1:0] cap_sec,
  output logic             irq_pri,
  output logic             irq_sec,
  output logic             ovf
);

  // named internal events, visible to the bound checker
  logic cnt_wrap;
  logic acc_level;
  logic edge_rise;
  logic edge_fall;
  logic trig_pri;
  logic trig_sec;

  pwc_counter #(.CW(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .ovf_clr (ovf_clr),
    .count   (count),
    .ovf     (ovf),
    .wrap    (cnt_wrap)
  );

  pwc_edge_filter #(.DEPTH(FILT_DEPTH)) u_filt (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .din     (cap_in),
    .level   (acc_level),
    .rise_ok (edge_rise),
    .fall_ok (edge_fall)
  );

  pwc_capture #(.CW(CNT_W)) u_cap (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .rise_ok  (edge_rise),
    .fall_ok  (edge_fall),
    .edge_sel (edge_sel),
    .count    (count),
    .cap_pri  (cap_pri),
    .cap_sec  (cap_sec),
    .irq_pri  (irq_pri),
    .irq_sec  (irq_sec),
    .hit_pri  (trig_pri),
    .hit_sec  (trig_sec)
  );

endmodule

// File: rtl/pwc_checker.sv
module pwc_checker #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          tick,
  input logic [1:0]    edge_sel,
  input logic [CW-1:0] count,
  input logic [CW-1:0] cap_pri,
  input logic [CW-1:0] cap_sec,
  input logic          irq_pri,
  input logic          irq_sec,
  input logic          ovf,
  input logic          wrap,
  input logic          edge_rise,
  input logic          edge_fall,
  input logic          trig_pri,
  input logic          trig_sec
);

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> count == CW'($past(count) + 1'b1));

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(count));

  // R3
  edge_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (edge_rise || edge_fall) |-> tick);

  // R6
  any_mode_no_sec_chk: assert property (@(posedge clk) disable iff (rst)
    edge_sel[1] |-> !trig_sec);

  // R5
  pri_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
    irq_pri |-> $past(tick));

  // R5
  pri_load_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(cap_pri) |-> irq_pri);

  // R6
  sec_load_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(cap_sec) |-> irq_sec);

  // R7
  ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
    wrap |=> ovf);

  // R7
  ovf_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf) |-> count == '0);

  // R9
  pri_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    irq_pri |=> !irq_pri);

  // R9
  sec_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    irq_sec |=> !irq_sec);

  // R9
  irq_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(irq_pri && irq_sec));

endmodule

bind pulse_width_capture pwc_checker #(.CW(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tick      (tick),
  .edge_sel  (edge_sel),
  .count     (count),
  .cap_pri   (cap_pri),
  .cap_sec   (cap_sec),
  .irq_pri   (irq_pri),
  .irq_sec   (irq_sec),
  .ovf       (ovf),
  .wrap      (cnt_wrap),
  .edge_rise (edge_rise),
  .edge_fall (edge_fall),
  .trig_pri  (trig_pri),
  .trig_sec  (trig_sec)
);

// File: tb/pulse_width_capture_test.sv
module pulse_width_capture_test;

  logic        clk = 1'b0;
  logic        rst, tick, cap_in, ovf_clr;
  logic [1:0]  edge_sel;
  logic [15:0] count, cap_pri, cap_sec;
  logic        irq_pri, irq_sec, ovf;

  always #2 clk = ~clk;  // 250 MHz

  pulse_width_capture uut (
    .clk(clk), .rst(rst), .tick(tick), .cap_in(cap_in), .edge_sel(edge_sel),
    .ovf_clr(ovf_clr), .count(count), .cap_pri(cap_pri), .cap_sec(cap_sec),
    .irq_pri(irq_pri), .irq_sec(irq_sec), .ovf(ovf)
  );

  int n_cmp = 0, n_bad = 0;
  int tcount = 0;
  int seen_pri = 0, seen_sec = 0, want_pri = 0, want_sec = 0;
  int exp_pri = 0, exp_sec = 0;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one tick, then gap idle cycles; strobes sampled once per tick
  task automatic tk(input int gap);
    tick = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tick = 1'b0;
    tcount++;
    if (irq_pri) seen_pri++;
    if (irq_sec) seen_sec++;
    repeat (gap) @(negedge clk);
  endtask

  // model of one accepted edge; change made after tcount ticks
  task automatic account(input logic dir, input int k, input logic [1:0] mode);
    logic pri, sec;
    pri = mode[1] ? 1'b1 : (mode[0] ? dir : !dir);
    sec = mode[1] ? 1'b0 : (mode[0] ? !dir : dir);
    if (pri) begin exp_pri = (k + 2) % 65536; want_pri++; end
    if (sec) begin exp_sec = (k + 2) % 65536; want_sec++; end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " R4/R5 cap_pri"}, int'(cap_pri), exp_pri);
    chk({tag, " R6 cap_sec"}, int'(cap_sec), exp_sec);
    chk({tag, " R9 irq_pri count"}, seen_pri, want_pri);
    chk({tag, " R6/R9 irq_sec count"}, seen_sec, want_sec);
  endtask

  task automatic pulse(input int w, input int gap);
    logic d;
    int   k0, k1;
    d  = !cap_in;
    k0 = tcount;
    cap_in = d;
    repeat (w) tk(gap);
    k1 = tcount;
    cap_in = !d;
    repeat (4) tk(gap);
    if (w >= 2) begin
      account(d, k0, edge_sel);
      account(!d, k1, edge_sel);
      check_all("sweep");
    end else begin
      check_all("R3 glitch");
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; tick = 1'b0; cap_in = 1'b0; edge_sel = 2'b00; ovf_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 count", int'(count), 0);
    chk("R1 cap_pri", int'(cap_pri), 0);
    chk("R1 cap_sec", int'(cap_sec), 0);
    chk("R1 ovf", int'(ovf), 0);
    chk("R1 irq", int'({irq_pri, irq_sec}), 0);

    // R2 stepping and holding
    repeat (5) tk(1);
    chk("R2 count after ticks", int'(count), tcount);
    repeat (4) @(negedge clk);
    chk("R2 count holds", int'(count), tcount);

    // R7 clear with no rollover leaves flag low
    ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
    chk("R7 ovf idle", int'(ovf), 0);

    // sweep over every mode value, widths and tick spacings
    for (int m = 0; m < 4; m++) begin
      edge_sel = 2'(m);
      for (int w = 1; w <= 8; w++) pulse(w, (m + w) % 3);
    end
    chk("R2 count after sweep", int'(count), tcount % 65536);

    // rollover region: fast ticks, rising mode, input low first
    edge_sel = 2'b01;
    if (cap_in) begin
      cap_in = 1'b0;
      account(1'b0, tcount, edge_sel);
      repeat (4) tk(0);
    end
    while (tcount < 65528) tk(0);
    chk("R7 ovf before rollover", int'(ovf), 0);
    begin
      int k0, k1;
      k0 = tcount;
      cap_in = 1'b1;
      repeat (10) tk(0);
      k1 = tcount;
      cap_in = 1'b0;
      repeat (6) tk(0);
      account(1'b1, k0, edge_sel);
      account(1'b0, k1, edge_sel);
    end
    check_all("wrap");
    chk("R8 width across rollover", int'(16'(cap_sec - cap_pri)), 10);
    chk("R2 count wrapped", int'(count), tcount % 65536);
    chk("R7 ovf set", int'(ovf), 1);
    repeat (5) tk(1);
    chk("R7 ovf sticky", int'(ovf), 1);
    ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
    chk("R7 ovf cleared", int'(ovf), 0);

    // R8 short width after rollover, falling mode
    edge_sel = 2'b00;
    cap_in = 1'b1; account(1'b1, tcount, edge_sel); repeat (4) tk(1);
    pulse(3, 2);
    chk("R8 low pulse width", int'(16'(cap_sec - cap_pri)), 3);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule